// File: doc/BRIEF.md
# Multi-Block Word Buffer Controller

This block is the staging store between a host register port and the data engine of an SD-style card interface. It holds 16-bit words in first-in, first-out order. Its status flags describe whole blocks, not single words. Buffer write enable says that one more complete block fits, even when earlier blocks are still waiting. Buffer read enable says that at least one complete block is waiting. The default store is 1024 words, which is 2 kB. It therefore holds two blocks of the largest size at the same time, so one side can fill a block while the other side drains the previous one.

A transfer-direction input selects which side writes and which side reads. When the host sends data to the card, the host writes words and the card side pops them. When data comes from the card, the card side pushes words and the host reads them. The block size arrives as a raw register value in bytes. The block removes the ignored upper bits and clamps the size to the maximum. It then rounds the size up to whole words and uses that word count for both flags. A wake pulse empties the store in one cycle; the controller uses it when it leaves a low-power state.

Top module: `mbuf_ctrl`

## Requirements
- R1: The store holds up to DEPTH words (default 1024, which is 2 kB), and `level_o` counts from 0 to DEPTH. Words leave in the order they entered. While `level_o` is nonzero, `rd_data_o` shows the oldest stored word without waiting for a pop.
- R2: `blk_size_i` bits [11:0] give the block size in bytes. Bits [14:12] have no effect on any output.
- R3: The effective block length `eff_words_o` is ceil(bytes/2). A size of zero counts as 1 word. Any size above MAX_BYTES (default 1024) counts as exactly MAX_BYTES, which is 512 words by default.
- R4: `wr_room_o` is 1 exactly when DEPTH minus `level_o` is at least `eff_words_o`.
- R5: `rd_avail_o` is 1 exactly when `level_o` is at least `eff_words_o`.
- R6: With `xfer_dir_i`=0 (host to card), `host_wr_i` pushes `host_wdata_i` and `card_pop_i` pops. With `xfer_dir_i`=1 (card to host), `card_push_i` pushes `card_wdata_i` and `host_rd_i` pops. The two strobes of the unselected pairing have no effect.
- R7: Whether a push or a pop is accepted depends on `level_o` at the start of the cycle. If a push and a pop are both accepted in one cycle, `level_o` does not change and both take effect. A push at full is dropped even when a pop happens in the same cycle, and so is a pop at empty with a push.
- R8: A `wake_i` pulse sets `level_o` to 0 on the next cycle and discards any push or pop in the same cycle. It leaves both error flags unchanged.
- R9: A push at full is dropped and sets `ovf_err_o`. A pop at empty is dropped and sets `udf_err_o`. Each flag stays set until `rst_n` is low.
- R10: After a synchronous active-low reset, `level_o`=0, `wr_room_o`=1, `rd_avail_o`=0 and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| xfer_dir_i | input | 1 | 0 = host to card, 1 = card to host |
| blk_size_i | input | REG_W (15) | Raw block size register value in bytes |
| wake_i | input | 1 | Empties the store (leaving a low-power state) |
| host_wr_i | input | 1 | Host word write strobe |
| host_wdata_i | input | DATA_W (16) | Host write data |
| host_rd_i | input | 1 | Host word read strobe |
| card_push_i | input | 1 | Card-side word push strobe |
| card_wdata_i | input | DATA_W (16) | Card-side push data |
| card_pop_i | input | 1 | Card-side word pop strobe |
| rd_data_o | output | DATA_W (16) | Oldest stored word |
| level_o | output | clog2(DEPTH+1) | Stored word count |
| eff_words_o | output | clog2(MAX_WORDS+1) | Effective block length in words |
| wr_room_o | output | 1 | Room for one more whole block |
| rd_avail_o | output | 1 | At least one whole block stored |
| ovf_err_o | output | 1 | Sticky: a push arrived at full |
| udf_err_o | output | 1 | Sticky: a pop arrived at empty |

## Verification
The events that collide are a push and a pop in the same cycle, and a wake in the same cycle as a push or pop. The bench produces the first collision in the middle of the store, at full and at empty. It produces the second right after the store has been filled, with strobes from the wrong pairing also asserted. A model of the requirements, kept in the bench, predicts the level, the head word, both flags and the sticky errors after every cycle. All of these are compared with the design's outputs for every block length from 1 to the clamped maximum in a small configuration. The clamp and bytes-to-words conversion is swept over every raw register value.

// File: rtl/mbuf_pkg.sv
// Shared definitions for the multi-block word buffer.
// Assumes 16-bit words, so the buffer always counts two bytes to a word.
package mbuf_pkg;

    localparam int unsigned BYTES_PER_WORD = 2;

    typedef enum logic {
        DIR_TO_CARD   = 1'b0,
        DIR_FROM_CARD = 1'b1
    } xfer_dir_e;

    // Number of words needed to carry a byte count, rounded up
    function automatic int unsigned words_for_bytes(input int unsigned nbytes);
        return (nbytes + BYTES_PER_WORD - 1) / BYTES_PER_WORD;
    endfunction

endpackage

// File: rtl/mbuf_size_map.sv
// Converts the raw block size register value into an effective word count.
// Assumes the size field is the low FIELD_W bits; the upper bits are ignored.
// A zero size gives one word; sizes above MAX_BYTES clamp to MAX_BYTES.
module mbuf_size_map #(
    parameter int REG_W     = 15,
    parameter int FIELD_W   = 12,
    parameter int MAX_BYTES = 1024,
    localparam int MAX_WORDS = int'(mbuf_pkg::words_for_bytes(MAX_BYTES)),
    localparam int WORDS_W   = $clog2(MAX_WORDS + 1)
) (
    input  logic [REG_W-1:0]   blk_size_i,
    output logic [WORDS_W-1:0] eff_words_o
);

    localparam int FIELD_MAX = (2 ** FIELD_W) - 1;

    logic [FIELD_W-1:0] field;
    logic [FIELD_W:0]   rounded;
    logic               over;
    logic               unused_hi;

    assign field     = blk_size_i[FIELD_W-1:0];
    assign unused_hi = ^blk_size_i[REG_W-1:FIELD_W];
    assign rounded   = ({1'b0, field} + {{FIELD_W{1'b0}}, 1'b1}) >> 1;

    // The clamp comparator is only built when the field can exceed the maximum
    generate
        if (MAX_BYTES >= FIELD_MAX) begin : g_noclamp
            assign over = 1'b0;
        end else begin : g_clamp
            assign over = (field > FIELD_W'(MAX_BYTES));
        end
    endgenerate

    // Select clamped, minimum or rounded word count
    always_comb begin
        if (over) begin
            eff_words_o = WORDS_W'(MAX_WORDS);
        end else if (field == '0) begin
            eff_words_o = WORDS_W'(1);
        end else begin
            eff_words_o = rounded[WORDS_W-1:0];
        end
    end

endmodule

// File: rtl/mbuf_store.sv
// Word storage array with one write port and an asynchronous read port.
// Assumes the caller only asserts we_i for a legal free slot; contents are not reset.
module mbuf_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1024,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Write the accepted word into its slot
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    // Present the head word continuously
    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/mbuf_ptrs.sv
// Read/write pointers, occupancy count and sticky error flags.
// Assumes DEPTH is a power of two so the pointers wrap naturally.
// Acceptance is decided on the count at the start of the cycle; wake wins over all.
module mbuf_ptrs #(
    parameter int DEPTH = 1024,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wake_i,
    input  logic              push_req_i,
    input  logic              pop_req_i,
    output logic              push_ok_o,
    output logic [ADDR_W-1:0] wr_ptr_o,
    output logic [ADDR_W-1:0] rd_ptr_o,
    output logic [LVL_W-1:0]  level_o,
    output logic              ovf_err_o,
    output logic              udf_err_o
);

    logic full;
    logic empty;
    logic pop_ok;

    assign full      = (level_o == LVL_W'(DEPTH));
    assign empty     = (level_o == '0);
    assign push_ok_o = push_req_i & ~wake_i & ~full;
    assign pop_ok    = pop_req_i & ~wake_i & ~empty;

    // Advance pointers and count, or clear them on wake
    always_ff @(posedge clk) begin
        if (!rst_n || wake_i) begin
            wr_ptr_o <= '0;
            rd_ptr_o <= '0;
            level_o  <= '0;
        end else begin
            if (push_ok_o) begin
                wr_ptr_o <= wr_ptr_o + ADDR_W'(1);
            end
            if (pop_ok) begin
                rd_ptr_o <= rd_ptr_o + ADDR_W'(1);
            end
            if (push_ok_o && !pop_ok) begin
                level_o <= level_o + LVL_W'(1);
            end else if (pop_ok && !push_ok_o) begin
                level_o <= level_o - LVL_W'(1);
            end
        end
    end

    // Latch dropped accesses until reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_err_o <= 1'b0;
            udf_err_o <= 1'b0;
        end else begin
            if (push_req_i && !wake_i && full) begin
                ovf_err_o <= 1'b1;
            end
            if (pop_req_i && !wake_i && empty) begin
                udf_err_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/mbuf_ctrl.sv
// Multi-block word buffer between a host port and a card-side data engine.
// The direction input picks which side pushes and which pops. The flags compare
// the occupancy against the effective block length in words.
// Assumes DEPTH is a power of two and MAX_BYTES/2 does not exceed DEPTH.
module mbuf_ctrl #(
    parameter int DATA_W    = 16,
    parameter int DEPTH     = 1024,
    parameter int REG_W     = 15,
    parameter int FIELD_W   = 12,
    parameter int MAX_BYTES = 1024,
    localparam int ADDR_W    = $clog2(DEPTH),
    localparam int LVL_W     = $clog2(DEPTH + 1),
    localparam int MAX_WORDS = int'(mbuf_pkg::words_for_bytes(MAX_BYTES)),
    localparam int WORDS_W   = $clog2(MAX_WORDS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xfer_dir_i,
    input  logic [REG_W-1:0]   blk_size_i,
    input  logic               wake_i,
    input  logic               host_wr_i,
    input  logic [DATA_W-1:0]  host_wdata_i,
    input  logic               host_rd_i,
    input  logic               card_push_i,
    input  logic [DATA_W-1:0]  card_wdata_i,
    input  logic               card_pop_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic [LVL_W-1:0]   level_o,
    output logic [WORDS_W-1:0] eff_words_o,
    output logic               wr_room_o,
    output logic               rd_avail_o,
    output logic               ovf_err_o,
    output logic               udf_err_o
);

    import mbuf_pkg::*;

    xfer_dir_e         dir;
    logic              push_req;
    logic              pop_req;
    logic              push_ok;
    logic [DATA_W-1:0] push_data;
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_ptr;
    logic [LVL_W-1:0]  blk_ext;
    logic [LVL_W-1:0]  free_words;

    assign dir = xfer_dir_e'(xfer_dir_i);

    // Route the strobes and data of the selected pairing
    always_comb begin
        if (dir == DIR_FROM_CARD) begin
            push_req  = card_push_i;
            push_data = card_wdata_i;
            pop_req   = host_rd_i;
        end else begin
            push_req  = host_wr_i;
            push_data = host_wdata_i;
            pop_req   = card_pop_i;
        end
    end

    mbuf_size_map #(
        .REG_W    (REG_W),
        .FIELD_W  (FIELD_W),
        .MAX_BYTES(MAX_BYTES)
    ) u_size (
        .blk_size_i (blk_size_i),
        .eff_words_o(eff_words_o)
    );

    mbuf_ptrs #(
        .DEPTH(DEPTH)
    ) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_i    (wake_i),
        .push_req_i(push_req),
        .pop_req_i (pop_req),
        .push_ok_o (push_ok),
        .wr_ptr_o  (wr_ptr),
        .rd_ptr_o  (rd_ptr),
        .level_o   (level_o),
        .ovf_err_o (ovf_err_o),
        .udf_err_o (udf_err_o)
    );

    mbuf_store #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH)
    ) u_store (
        .clk    (clk),
        .we_i   (push_ok),
        .waddr_i(wr_ptr),
        .wdata_i(push_data),
        .raddr_i(rd_ptr),
        .rdata_o(rd_data_o)
    );

    // Block-granular status flags
    assign blk_ext    = LVL_W'(eff_words_o);
    assign free_words = LVL_W'(DEPTH) - level_o;
    assign wr_room_o  = (free_words >= blk_ext);
    assign rd_avail_o = (level_o >= blk_ext);

endmodule

// File: rtl/mbuf_ctrl_chk.sv
// Property checker for mbuf_ctrl, attached with bind.
// Assumes the same DEPTH and MAX_BYTES as the bound instance.
module mbuf_ctrl_chk #(
    parameter int DEPTH     = 1024,
    parameter int MAX_BYTES = 1024,
    localparam int LVL_W     = $clog2(DEPTH + 1),
    localparam int MAX_WORDS = int'(mbuf_pkg::words_for_bytes(MAX_BYTES)),
    localparam int WORDS_W   = $clog2(MAX_WORDS + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               xfer_dir_i,
    input logic               wake_i,
    input logic               host_wr_i,
    input logic               host_rd_i,
    input logic               card_push_i,
    input logic               card_pop_i,
    input logic [LVL_W-1:0]   level_o,
    input logic [WORDS_W-1:0] eff_words_o,
    input logic               rd_avail_o,
    input logic               ovf_err_o,
    input logic               udf_err_o
);

    logic push_req;
    logic pop_req;

    assign push_req = xfer_dir_i ? card_push_i : host_wr_i;
    assign pop_req  = xfer_dir_i ? host_rd_i : card_pop_i;

    // R1: the count never passes the capacity
    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= LVL_W'(DEPTH));

    // R3: effective length stays between one word and the clamp
    assert_clamp_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_words_o != '0) && (eff_words_o <= WORDS_W'(MAX_WORDS)));

    // R5: a whole block available implies a nonempty store
    assert_avail_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_avail_o |-> (level_o != '0));

    // R7: paired push and pop in the middle leave the count unchanged
    assert_pair_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && !wake_i && level_o != '0 && level_o != LVL_W'(DEPTH))
        |=> $stable(level_o));

    // R8: wake empties the store on the next cycle
    assert_wake_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_i |=> (level_o == '0) && !rd_avail_o);

    // R9: a push at full raises the overflow flag
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !wake_i && level_o == LVL_W'(DEPTH)) |=> ovf_err_o);

    // R9: a pop at empty raises the underflow flag
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !wake_i && level_o == '0) |=> udf_err_o);

    // R9: error flags hold until reset
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err_o |=> ovf_err_o);

    assert_udf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        udf_err_o |=> udf_err_o);

endmodule

bind mbuf_ctrl mbuf_ctrl_chk #(
    .DEPTH    (DEPTH),
    .MAX_BYTES(MAX_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_dir_i (xfer_dir_i),
    .wake_i     (wake_i),
    .host_wr_i  (host_wr_i),
    .host_rd_i  (host_rd_i),
    .card_push_i(card_push_i),
    .card_pop_i (card_pop_i),
    .level_o    (level_o),
    .eff_words_o(eff_words_o),
    .rd_avail_o (rd_avail_o),
    .ovf_err_o  (ovf_err_o),
    .udf_err_o  (udf_err_o)
);

// File: tb/sim_mbuf_ctrl.sv
`timescale 1ns/1ps
// Bench for mbuf_ctrl in a small configuration: 16 words, 16-byte block limit.
module sim_mbuf_ctrl;

    localparam int DW   = 16;
    localparam int DEP  = 16;
    localparam int MAXB = 16;
    localparam int MAXW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xfer_dir_i = 1'b0;
    logic [14:0]   blk_size_i = '0;
    logic          wake_i = 1'b0;
    logic          host_wr_i = 1'b0;
    logic [DW-1:0] host_wdata_i = '0;
    logic          host_rd_i = 1'b0;
    logic          card_push_i = 1'b0;
    logic [DW-1:0] card_wdata_i = '0;
    logic          card_pop_i = 1'b0;
    logic [DW-1:0] rd_data_o;
    logic [4:0]    level_o;
    logic [3:0]    eff_words_o;
    logic          wr_room_o;
    logic          rd_avail_o;
    logic          ovf_err_o;
    logic          udf_err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Requirement model state
    int  m_level = 0;
    int  m_head  = 0;
    int  m_tail  = 0;
    bit  m_ovf   = 1'b0;
    bit  m_udf   = 1'b0;
    int  m_blk   = 1;

    always #5 clk = ~clk;

    mbuf_ctrl #(
        .DATA_W   (DW),
        .DEPTH    (DEP),
        .REG_W    (15),
        .FIELD_W  (12),
        .MAX_BYTES(MAXB)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer_dir_i  (xfer_dir_i),
        .blk_size_i  (blk_size_i),
        .wake_i      (wake_i),
        .host_wr_i   (host_wr_i),
        .host_wdata_i(host_wdata_i),
        .host_rd_i   (host_rd_i),
        .card_push_i (card_push_i),
        .card_wdata_i(card_wdata_i),
        .card_pop_i  (card_pop_i),
        .rd_data_o   (rd_data_o),
        .level_o     (level_o),
        .eff_words_o (eff_words_o),
        .wr_room_o   (wr_room_o),
        .rd_avail_o  (rd_avail_o),
        .ovf_err_o   (ovf_err_o),
        .udf_err_o   (udf_err_o)
    );

    function automatic logic [DW-1:0] dval(input int k);
        return DW'(k * 37 + 5);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Compare all observable outputs against the model
    task automatic check_state(input string req);
        chk(int'(level_o) == m_level, {req, " level"}, int'(level_o), m_level);
        chk(wr_room_o == ((DEP - m_level) >= m_blk), {req, " R4 wr_room"},
            int'(wr_room_o), int'((DEP - m_level) >= m_blk));
        chk(rd_avail_o == (m_level >= m_blk), {req, " R5 rd_avail"},
            int'(rd_avail_o), int'(m_level >= m_blk));
        chk(ovf_err_o == m_ovf, {req, " R9 ovf"}, int'(ovf_err_o), int'(m_ovf));
        chk(udf_err_o == m_udf, {req, " R9 udf"}, int'(udf_err_o), int'(m_udf));
        if (m_level > 0) begin
            chk(rd_data_o == dval(m_head), {req, " R1 head data"},
                int'(rd_data_o), int'(dval(m_head)));
        end
    endtask

    // One cycle: push/pop on the selected pairing, optional wake, optional
    // strobes on the unselected pairing (R6: must be ignored)
    task automatic step(input bit push, input bit pop, input bit wk, input bit noise,
                        input string req);
        bit push_ok;
        bit pop_ok;
        if (xfer_dir_i) begin
            card_push_i  = push;
            card_wdata_i = dval(m_tail);
            host_rd_i    = pop;
            host_wr_i    = noise;
            host_wdata_i = 16'hDEAD;
            card_pop_i   = noise;
        end else begin
            host_wr_i    = push;
            host_wdata_i = dval(m_tail);
            card_pop_i   = pop;
            card_push_i  = noise;
            card_wdata_i = 16'hBEEF;
            host_rd_i    = noise;
        end
        wake_i = wk;
        push_ok = push && !wk && (m_level < DEP);
        pop_ok  = pop && !wk && (m_level > 0);
        if (push && !wk && m_level == DEP) m_ovf = 1'b1;
        if (pop && !wk && m_level == 0) m_udf = 1'b1;
        @(posedge clk);
        #1;
        host_wr_i = 1'b0; host_rd_i = 1'b0; card_push_i = 1'b0; card_pop_i = 1'b0;
        wake_i = 1'b0;
        if (wk) begin
            m_level = 0;
            m_head  = m_tail;
        end else begin
            if (push_ok) begin m_tail++; m_level++; end
            if (pop_ok)  begin m_head++; m_level--; end
        end
        check_state(req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        m_level = 0; m_head = m_tail; m_ovf = 1'b0; m_udf = 1'b0;
        check_state("R10 reset");
    endtask

    // Watchdog: a hung run is a failure and still prints the summary
    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R2/R3: sweep every raw register value through the size mapping
        for (int v = 0; v < 32768; v++) begin
            int f;
            int e;
            blk_size_i = 15'(v);
            #1;
            f = v & 12'hFFF;
            e = (f > MAXB) ? MAXW : ((f == 0) ? 1 : (f + 1) / 2);
            chk(int'(eff_words_o) == e, "R2 R3 size map", int'(eff_words_o), e);
        end

        do_reset();

        for (int w = 1; w <= MAXW; w++) begin
            // Odd byte count for odd w, bits 14:12 set to junk (R2)
            blk_size_i = {3'(w), 12'(2 * w - (w % 2))};
            m_blk = w;
            xfer_dir_i = w[0];
            do_reset();
            // R1/R4/R5: fill past full; the last push overflows (R9)
            for (int i = 0; i <= DEP; i++) step(1'b1, 1'b0, 1'b0, i[0], "R1 fill");
            // R1/R9: drain past empty; the last pop underflows
            for (int i = 0; i <= DEP; i++) step(1'b0, 1'b1, 1'b0, i[1], "R1 drain");
            // R7: paired traffic at empty, middle and full
            step(1'b1, 1'b1, 1'b0, 1'b0, "R7 pair at empty");
            for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R1 refill");
            for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b0, 1'b1, "R7 pair mid");
            while (m_level < DEP) step(1'b1, 1'b0, 1'b0, 1'b0, "R1 to full");
            step(1'b1, 1'b1, 1'b0, 1'b0, "R7 pair at full");
            // R6: only unselected strobes for a few cycles
            for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b1, "R6 ignored");
            // R8: wake collides with push, pop and noise; errors keep
            step(1'b1, 1'b1, 1'b1, 1'b1, "R8 wake");
            for (int i = 0; i < w; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R8 after wake");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule